// File: doc/BRIEF.md
# Latched High-High Process Trip

This block guards one piece of process equipment against an excessive analog reading. Each clock it compares an unsigned process value against a high-high trip limit. When the value reaches that limit, the block latches a trip. The trip removes the equipment run command and closes the feed valve. It also raises a trip indication that stays on for as long as the trip is latched, and a one-cycle alarm pulse for the operator display.

An operator acknowledge clears the latched trip, but only once the process value has fallen strictly below a second, lower reset limit. This gives reset hysteresis on top of the manual acknowledge. Clearing the trip never restarts the equipment: the run request input must drop and then be asserted again before the run command returns.

The controller is a four-state machine.
- States: `ST_IDLE` (stopped, healthy), `ST_RUN` (running), `ST_TRIP` (latched trip) and `ST_HOLD` (trip cleared, waiting for the run request to be released).
- Transitions:
  - `T_START`: `ST_IDLE` to `ST_RUN`, on a run request with no trip.
  - `T_STOP`: `ST_RUN` to `ST_IDLE`, when the run request drops.
  - `T_TRIP`: any state to `ST_TRIP`, when the value is at or above the high-high limit.
  - `T_CLEAR_HOLD`: `ST_TRIP` to `ST_HOLD`, on an accepted acknowledge while the run request is still high.
  - `T_CLEAR_IDLE`: `ST_TRIP` to `ST_IDLE`, on an accepted acknowledge while the run request is low.
  - `T_RELEASE`: `ST_HOLD` to `ST_IDLE`, when the run request drops.

Top module: `hh_trip_guard`

## Requirements
- R1: While `rst_n` is low, all four outputs are 0 and the state is `ST_IDLE`, whatever the inputs are.
- R2: At a clock edge where `pv_i >= hh_limit_i` (unsigned), `trip_o` reads 1 right after that same edge.
- R3: Whenever `trip_o` is 1, both `run_cmd_o` and `valve_open_o` are 0.
- R4: Once set, `trip_o` stays 1 on every edge that does not carry an accepted acknowledge, even after `pv_i` falls.
- R5: An acknowledge (`ack_i` = 1) is accepted only when `pv_i < reset_limit_i` (strict) and `pv_i < hh_limit_i`. With `pv_i` equal to the reset limit, the trip stays latched.
- R6: An acknowledge that is refused is not remembered. If `pv_i` later falls below the reset limit while `ack_i` is 0, the trip stays set.
- R7: `alarm_pulse_o` is 1 for exactly the one cycle after the edge where `trip_o` goes from 0 to 1, and is 0 at all other times.
- R8: After the trip clears, `run_cmd_o` stays 0 while `run_req_i` remains 1. The run command returns only after `run_req_i` has been seen at 0 on an edge and then at 1 on a later edge.
- R9: With no trip and no hold, `run_cmd_o` and `valve_open_o` both follow `run_req_i` with one register delay.
- R10: A value at or above the high-high limit sets the trip regardless of `ack_i` and `run_req_i`, including from `ST_IDLE` and `ST_HOLD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pv_i | input | 16 | Process value, unsigned |
| hh_limit_i | input | 16 | High-high trip limit, unsigned |
| reset_limit_i | input | 16 | Limit below which acknowledge is accepted |
| ack_i | input | 1 | Operator acknowledge / reset request |
| run_req_i | input | 1 | Equipment run request, level |
| run_cmd_o | output | 1 | Gated equipment run command |
| valve_open_o | output | 1 | Feed-valve open command |
| trip_o | output | 1 | Latched trip indication |
| alarm_pulse_o | output | 1 | One-cycle pulse when the trip is set |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- Value exactly equal to the trip limit: a strict comparison would miss the trip.
- Value exactly equal to the reset limit: an inclusive comparison would clear too early.
- An acknowledge given while the value is still high and then released: a design that stored it would clear later without a fresh acknowledge.
- Trip clear with the run request still held: a design without the hold state would restart the equipment on its own.

It also checks that the alarm pulse lasts only one cycle while the value stays above the limit, and that a trip asserted together with an acknowledge still latches. Long random runs with values clustered around both limits cross-check all outputs against a bench model on every cycle.

// File: rtl/hh_trip_pkg.sv
package hh_trip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TRIP = 2'd2,
        ST_HOLD = 2'd3
    } trip_state_e;

endpackage

// File: rtl/hh_trip_cmp.sv
module hh_trip_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] pv_i,
    input  logic [W-1:0] hh_limit_i,
    input  logic [W-1:0] reset_limit_i,
    output logic         over_hh_o,
    output logic         reset_ok_o
);

    // Unsigned compare: trip is inclusive, reset window is strict.
    always_comb begin
        over_hh_o  = (pv_i >= hh_limit_i);
        reset_ok_o = (pv_i < reset_limit_i) && !(pv_i >= hh_limit_i);
    end

endmodule

// File: rtl/hh_trip_fsm.sv
module hh_trip_fsm
    import hh_trip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic over_hh_i,
    input  logic reset_ok_i,
    input  logic ack_i,
    input  logic run_req_i,
    output logic run_cmd_o,
    output logic valve_open_o,
    output logic trip_o,
    output logic alarm_pulse_o
);

    trip_state_e state_q;
    trip_state_e state_d;

    // Next-state logic: the high-high condition outranks every other input.
    always_comb begin
        state_d = state_q;
        if (over_hh_i) begin
            state_d = ST_TRIP;                          // T_TRIP
        end else begin
            unique case (state_q)
                ST_IDLE: if (run_req_i)  state_d = ST_RUN;   // T_START
                ST_RUN:  if (!run_req_i) state_d = ST_IDLE;  // T_STOP
                ST_TRIP: if (ack_i && reset_ok_i)
                             state_d = run_req_i ? ST_HOLD    // T_CLEAR_HOLD
                                                 : ST_IDLE;   // T_CLEAR_IDLE
                ST_HOLD: if (!run_req_i) state_d = ST_IDLE;  // T_RELEASE
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cmd_o     <= 1'b0;
            valve_open_o  <= 1'b0;
            trip_o        <= 1'b0;
            alarm_pulse_o <= 1'b0;
        end else begin
            run_cmd_o     <= (state_d == ST_RUN);
            valve_open_o  <= (state_d == ST_RUN);
            trip_o        <= (state_d == ST_TRIP);
            alarm_pulse_o <= (state_d == ST_TRIP) && (state_q != ST_TRIP);
        end
    end

    assert_trip_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        over_hh_i |=> trip_o);

    assert_trip_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |-> (!run_cmd_o && !valve_open_o));

    assert_trip_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_o && !ack_i) |=> trip_o);

    assert_reset_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_o && !reset_ok_i) |=> trip_o);

    assert_alarm_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse_o |=> !alarm_pulse_o);

    assert_alarm_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o) |-> alarm_pulse_o);

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trip_o) |-> !run_cmd_o);

    assert_run_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_cmd_o) |-> $past(run_req_i));

endmodule

// File: rtl/hh_trip_guard.sv
module hh_trip_guard #(
    parameter int PV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PV_W-1:0] pv_i,
    input  logic [PV_W-1:0] hh_limit_i,
    input  logic [PV_W-1:0] reset_limit_i,
    input  logic            ack_i,
    input  logic            run_req_i,
    output logic            run_cmd_o,
    output logic            valve_open_o,
    output logic            trip_o,
    output logic            alarm_pulse_o
);

    logic over_hh;
    logic reset_ok;

    hh_trip_cmp #(.W(PV_W)) u_cmp (
        .pv_i          (pv_i),
        .hh_limit_i    (hh_limit_i),
        .reset_limit_i (reset_limit_i),
        .over_hh_o     (over_hh),
        .reset_ok_o    (reset_ok)
    );

    hh_trip_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .over_hh_i     (over_hh),
        .reset_ok_i    (reset_ok),
        .ack_i         (ack_i),
        .run_req_i     (run_req_i),
        .run_cmd_o     (run_cmd_o),
        .valve_open_o  (valve_open_o),
        .trip_o        (trip_o),
        .alarm_pulse_o (alarm_pulse_o)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!run_cmd_o && !valve_open_o && !trip_o && !alarm_pulse_o));

    assert_trip_any_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_i >= hh_limit_i) |=> (trip_o && !run_cmd_o));

endmodule

// File: tb/tb_hh_trip_guard.sv
module tb_hh_trip_guard;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam logic [W-1:0] HH  = 16'd1000;
    localparam logic [W-1:0] RST = 16'd800;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pv = '0;
    logic [W-1:0] hh_lim = HH;
    logic [W-1:0] rs_lim = RST;
    logic         ack = 1'b0;
    logic         req = 1'b0;
    logic         run_cmd, valve, trip, alarm;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state
    bit m_trip, m_lock, m_run, m_alarm;

    always #(CLK_PERIOD/2) clk = ~clk;

    hh_trip_guard #(.PV_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .pv_i(pv), .hh_limit_i(hh_lim),
        .reset_limit_i(rs_lim), .ack_i(ack), .run_req_i(req),
        .run_cmd_o(run_cmd), .valve_open_o(valve), .trip_o(trip),
        .alarm_pulse_o(alarm)
    );

    task automatic check(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update from requirements R2..R10 for one edge
    task automatic model_edge(input logic [W-1:0] v, input bit a, input bit r);
        bit prev_trip;
        prev_trip = m_trip;
        m_alarm = 1'b0;
        if (v >= hh_lim) begin                 // R2, R10
            m_trip  = 1'b1;
            m_run   = 1'b0;
            m_lock  = 1'b0;
            m_alarm = !prev_trip;              // R7
        end else if (m_trip) begin
            if (a && v < rs_lim) begin         // R5
                m_trip = 1'b0;
                m_lock = r;                    // R8
            end
            m_run = 1'b0;                      // R3
        end else if (m_lock) begin
            if (!r) m_lock = 1'b0;             // R8
            m_run = 1'b0;
        end else begin
            m_run = r;                         // R9
        end
    endtask

    task automatic step(input string tag, input logic [W-1:0] v, input bit a, input bit r);
        pv = v; ack = a; req = r;
        model_edge(v, a, r);
        @(posedge clk);
        #1;
        check({tag, " trip R2/R4"}, trip, m_trip);
        check({tag, " run R3/R9"}, run_cmd, m_run);
        check({tag, " valve R3"}, valve, m_run);
        check({tag, " alarm R7"}, alarm, m_alarm);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] v;
        bit a, r;
        void'($urandom(32'h5eed_1234));
        // R1: reset dominates even with a tripping value and a run request
        pv = 16'd5000; req = 1'b1; ack = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 run", run_cmd, 1'b0);
        check("R1 valve", valve, 1'b0);
        check("R1 trip", trip, 1'b0);
        check("R1 alarm", alarm, 1'b0);
        pv = 16'd100; req = 1'b0; ack = 1'b0;
        rst_n = 1'b1;
        m_trip = 0; m_lock = 0; m_run = 0; m_alarm = 0;

        // R9: normal start/stop
        step("R9 start", 16'd100, 0, 1);
        step("R9 hold run", 16'd999, 0, 1);
        step("R9 stop", 16'd100, 0, 0);
        step("R9 restart", 16'd100, 0, 1);
        // R2: value equal to the limit trips; R7 pulse is one cycle
        step("R2 equal limit", HH, 0, 1);
        step("R7 still high", 16'd2000, 0, 1);
        // R4: latched after the value falls
        for (int i = 0; i < 3; i++) step("R4 latched", 16'd100, 0, 1);
        // R5: value equal to reset limit, ack refused
        step("R5 ack at reset limit", RST, 1, 1);
        // R6: ack released, value now low: still tripped
        step("R6 refused ack not kept", 16'd100, 0, 1);
        step("R6 again", 16'd10, 0, 1);
        // R5/R8: accepted just below the limit, run request held
        step("R8 clear with req held", RST - 16'd1, 1, 1);
        for (int i = 0; i < 3; i++) step("R8 no restart", 16'd100, 0, 1);
        step("R8 release", 16'd100, 0, 0);
        step("R8 new request", 16'd100, 0, 1);
        // R10: trip from idle and with ack present
        step("R10 stop", 16'd100, 0, 0);
        step("R10 trip from idle with ack", 16'hFFFF, 1, 0);
        step("R10 clear", 16'd0, 1, 0);
        step("R10 idle", 16'd0, 0, 1);

        // Random phase, values clustered on both limits
        r = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            case ($urandom_range(0, 5))
                0: v = HH;
                1: v = RST;
                2: v = RST - 16'd1;
                3: v = HH - 16'd1;
                4: v = 16'($urandom_range(0, 1200));
                default: v = 16'($urandom_range(0, 700));
            endcase
            a = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 7) == 0) r = !r;
            step("RND R2-R10 mix", v, a, r);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule